// File: doc/BRIEF.md
# MSI Address Pattern Matcher

This block sits in front of an I/O address translation walker. Each incoming device request carries an address, a write flag and the device's context fields for message-signalled interrupts: a page-table mode, a page-number pattern and a page-number mask. The block decides whether the request is a write aimed at a guest interrupt-file page. If it is, the request goes to an interrupt-trap path with an identity translation and the walker is skipped. If it is not, the request goes to the walker exactly as it arrived.

The decision takes the page number of the address, which is the address with its 12 offset bits dropped. It XORs that page number with the pattern and clears the bits that the mask marks as don't-care. A match needs the remaining value to be zero. A match also needs the global MSI enable, the flat mode in the context, and write permission. The result is registered. Requests use a valid/ready handshake. The block has two response channels, trap and walker, and each has its own ready. The stage holds one entry and passes back-pressure through to the request side.

Top module: `msi_bypass_matcher`

## Requirements
- R1: While `msi_enable` is low when a request is accepted, that request never matches. It appears on the walker channel and `trap_valid` stays low.
- R2: A request matches only if `ctx_mode` equals the flat encoding, value 1. Mode values 0, 2 and any other value send the request to the walker.
- R3: The page number is `req_addr[55:12]`. A match needs `((page number ^ ctx_pattern) & ~ctx_mask) == 0`. Pattern bits where the mask bit is 1 do not matter. A single unmasked differing bit prevents a match.
- R4: A request with `req_write` low never matches.
- R5: On a match, the trap channel presents `trap_addr` equal to the request address, `trap_page_mask` equal to 0xFFF, `trap_target` equal to 1 (trap path) and `res_match` high.
- R6: On no match, the walker channel presents `walk_addr` and `walk_write` equal to the request's values, with `res_match` low.
- R7: A request accepted on a clock edge shows its result on exactly one channel right after that edge.
- R8: A result that its channel has not yet accepted holds every field stable. `req_ready` is low while a result is held and its channel's ready is low. `req_ready` is high when the stage is empty or when the held result is leaving.
- R9: After reset, `trap_valid` and `walk_valid` are low and `req_ready` is high.
- R10: `trap_valid` and `walk_valid` are never high together.
- R11: Address bits 11:0 have no effect on the match decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_addr | input | 56 | Request address |
| req_write | input | 1 | Request has write permission |
| msi_enable | input | 1 | Global MSI support enable |
| ctx_mode | input | 4 | Context MSI page-table mode (1 = flat) |
| ctx_pattern | input | 44 | Context page-number pattern |
| ctx_mask | input | 44 | Context page-number don't-care mask |
| trap_valid | output | 1 | Trap-path result present |
| trap_ready | input | 1 | Trap path takes the result |
| trap_addr | output | 56 | Identity-translated address |
| trap_page_mask | output | 56 | Page-offset mask of the translation |
| trap_target | output | 1 | Target select, 1 = trap path |
| walk_valid | output | 1 | Walker-path request present |
| walk_ready | input | 1 | Walker takes the request |
| walk_addr | output | 56 | Forwarded request address |
| walk_write | output | 1 | Forwarded write flag |
| res_match | output | 1 | Match flag of the held result |

## Verification
The bench probes the edges of the masked compare. It flips one unmasked page-number bit, which must turn a hit into a miss. It flips the same bit under the mask, which must stay a hit. It varies only the offset bits, which must not change the result. An XOR or a mask with the wrong polarity, or a compare window shifted by one bit, would send traffic to the wrong channel. Reads, a cleared enable and non-flat modes must all reach the walker, so a missing gate shows up as a spurious trap. Long back-pressure periods with random readies check that a held result does not drift or get overwritten, and that `req_ready` follows the draining channel and not the other one.

// File: rtl/msi_match_pkg.sv
// Shared definitions for the MSI address pattern matcher.
// Assumes the flat-mode encoding and the page size are fixed per chip.
package msi_match_pkg;
    typedef enum logic {
        TGT_WALKER = 1'b0,
        TGT_TRAP   = 1'b1
    } trap_tgt_e;

    localparam int unsigned DEF_PAGE_BITS = 12;
    localparam int unsigned DEF_PPN_W     = 44;
    localparam int unsigned DEF_MODE_W    = 4;
    localparam int unsigned DEF_FLAT_MODE = 1;
endpackage

// File: rtl/msi_ppn_compare.sv
// Combinational decision: is this request a write into the context's
// interrupt-file page window? Assumes all inputs are stable while the
// request is offered.
module msi_ppn_compare #(
    parameter int unsigned PPN_W     = msi_match_pkg::DEF_PPN_W,
    parameter int unsigned PAGE_BITS = msi_match_pkg::DEF_PAGE_BITS,
    parameter int unsigned MODE_W    = msi_match_pkg::DEF_MODE_W,
    parameter int unsigned FLAT_MODE = msi_match_pkg::DEF_FLAT_MODE,
    localparam int unsigned ADDR_W   = PPN_W + PAGE_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              msi_on,
    input  logic [MODE_W-1:0] mode,
    input  logic [PPN_W-1:0]  pattern,
    input  logic [PPN_W-1:0]  mask,
    output logic              hit
);
    localparam logic [MODE_W-1:0] FLAT_CODE = MODE_W'(FLAT_MODE);

    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] care_diff;
    logic             gate_ok;

    assign ppn = addr[ADDR_W-1:PAGE_BITS];

    // One bit per page-number position: a difference where the mask cares.
    for (genvar b = 0; b < PPN_W; b++) begin : g_bit
        assign care_diff[b] = (ppn[b] ^ pattern[b]) & ~mask[b];
    end

    // Enable, mode and permission gates, then the zero test.
    always_comb begin
        gate_ok = msi_on && is_write && (mode == FLAT_CODE);
        hit     = gate_ok && (care_diff == '0);
    end
endmodule

// File: rtl/msi_result_stage.sv
// One-entry result register that steers to a trap channel or a walker
// channel. Assumes each downstream consumer may stall indefinitely; the
// request side sees ready pass through when the held entry drains.
module msi_result_stage #(
    parameter int unsigned ADDR_W = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_hit,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic              trap_ready,
    input  logic              walk_ready,
    output logic              trap_valid,
    output logic              walk_valid,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write
);
    logic occ;
    logic drain;
    logic take;

    // Handshake decode for the single entry.
    always_comb begin
        drain    = occ && (out_hit ? trap_ready : walk_ready);
        in_ready = !occ || drain;
        take     = in_valid && in_ready;
    end

    // Occupancy of the entry.
    always_ff @(posedge clk) begin
        if (!rst_n)      occ <= 1'b0;
        else if (take)   occ <= 1'b1;
        else if (drain)  occ <= 1'b0;
    end

    // Payload capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hit   <= 1'b0;
            out_addr  <= '0;
            out_write <= 1'b0;
        end else if (take) begin
            out_hit   <= in_hit;
            out_addr  <= in_addr;
            out_write <= in_write;
        end
    end

    assign trap_valid = occ && out_hit;
    assign walk_valid = occ && !out_hit;
endmodule

// File: rtl/msi_bypass_matcher.sv
// Top: early translation bypass for writes into interrupt-file pages.
// Matching writes leave on the trap channel with an identity translation;
// everything else leaves unchanged on the walker channel. Assumes the
// context fields are valid together with req_valid.
module msi_bypass_matcher #(
    parameter int unsigned PPN_W     = msi_match_pkg::DEF_PPN_W,
    parameter int unsigned PAGE_BITS = msi_match_pkg::DEF_PAGE_BITS,
    parameter int unsigned MODE_W    = msi_match_pkg::DEF_MODE_W,
    parameter int unsigned FLAT_MODE = msi_match_pkg::DEF_FLAT_MODE,
    localparam int unsigned ADDR_W   = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              msi_enable,
    input  logic [MODE_W-1:0] ctx_mode,
    input  logic [PPN_W-1:0]  ctx_pattern,
    input  logic [PPN_W-1:0]  ctx_mask,
    output logic              trap_valid,
    input  logic              trap_ready,
    output logic [ADDR_W-1:0] trap_addr,
    output logic [ADDR_W-1:0] trap_page_mask,
    output logic              trap_target,
    output logic              walk_valid,
    input  logic              walk_ready,
    output logic [ADDR_W-1:0] walk_addr,
    output logic              walk_write,
    output logic              res_match
);
    import msi_match_pkg::*;

    localparam logic [ADDR_W-1:0] OFFSET_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

    logic              hit_now;
    logic              held_hit;
    logic [ADDR_W-1:0] held_addr;
    logic              held_write;
    trap_tgt_e         tgt;

    msi_ppn_compare #(
        .PPN_W     (PPN_W),
        .PAGE_BITS (PAGE_BITS),
        .MODE_W    (MODE_W),
        .FLAT_MODE (FLAT_MODE)
    ) u_cmp (
        .addr     (req_addr),
        .is_write (req_write),
        .msi_on   (msi_enable),
        .mode     (ctx_mode),
        .pattern  (ctx_pattern),
        .mask     (ctx_mask),
        .hit      (hit_now)
    );

    msi_result_stage #(
        .ADDR_W (ADDR_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ready   (req_ready),
        .in_hit     (hit_now),
        .in_addr    (req_addr),
        .in_write   (req_write),
        .trap_ready (trap_ready),
        .walk_ready (walk_ready),
        .trap_valid (trap_valid),
        .walk_valid (walk_valid),
        .out_hit    (held_hit),
        .out_addr   (held_addr),
        .out_write  (held_write)
    );

    // Build the identity translation and the forwarded walker request.
    always_comb begin
        tgt            = held_hit ? TGT_TRAP : TGT_WALKER;
        trap_target    = tgt;
        trap_addr      = held_addr;
        trap_page_mask = held_hit ? OFFSET_MASK : '0;
        walk_addr      = held_addr;
        walk_write     = held_write;
        res_match      = held_hit && (trap_valid || walk_valid);
    end
endmodule

// File: rtl/msi_bypass_matcher_chk.sv
// Port-level checker for the MSI bypass matcher, bound to every instance.
module msi_bypass_matcher_chk #(
    parameter int unsigned PPN_W     = 44,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned MODE_W    = 4,
    parameter int unsigned FLAT_MODE = 1,
    localparam int unsigned ADDR_W   = PPN_W + PAGE_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              msi_enable,
    input logic [MODE_W-1:0] ctx_mode,
    input logic [PPN_W-1:0]  ctx_pattern,
    input logic [PPN_W-1:0]  ctx_mask,
    input logic              trap_valid,
    input logic              trap_ready,
    input logic [ADDR_W-1:0] trap_addr,
    input logic [ADDR_W-1:0] trap_page_mask,
    input logic              trap_target,
    input logic              walk_valid,
    input logic              walk_ready,
    input logic [ADDR_W-1:0] walk_addr,
    input logic              walk_write,
    input logic              res_match
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

    logic acc;
    assign acc = req_valid && req_ready;

    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_valid && walk_valid)); // R10
    AST_DISABLED_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !msi_enable |=> walk_valid && !trap_valid); // R1
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (ctx_mode != MODE_W'(FLAT_MODE)) |=> walk_valid); // R2
    AST_READ_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_write |=> walk_valid && !trap_valid); // R4
    AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_page_mask == OFS && trap_target && res_match); // R5
    AST_IDENTITY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> trap_addr == $past(req_addr) && walk_addr == $past(req_addr)); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> trap_valid || walk_valid); // R7
    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_ready |=> trap_valid && $stable(trap_addr)); // R8
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && !walk_ready |=> walk_valid && $stable(walk_addr) && $stable(walk_write)); // R8
    AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_ready) || (walk_valid && !walk_ready) |-> !req_ready); // R8
endmodule

bind msi_bypass_matcher msi_bypass_matcher_chk #(
    .PPN_W     (PPN_W),
    .PAGE_BITS (PAGE_BITS),
    .MODE_W    (MODE_W),
    .FLAT_MODE (FLAT_MODE)
) u_chk (.*);

// File: tb/tb_msi_bypass_matcher.sv
`timescale 1ns/1ps
module tb_msi_bypass_matcher;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [55:0] req_addr;
    logic        req_write;
    logic        msi_enable;
    logic [3:0]  ctx_mode;
    logic [43:0] ctx_pattern;
    logic [43:0] ctx_mask;
    logic        trap_valid;
    logic        trap_ready;
    logic [55:0] trap_addr;
    logic [55:0] trap_page_mask;
    logic        trap_target;
    logic        walk_valid;
    logic        walk_ready;
    logic [55:0] walk_addr;
    logic        walk_write;
    logic        res_match;

    always #(CLK_P/2) clk = ~clk;

    msi_bypass_matcher dut (.*);

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase_tag = "R9";

    // Reference model state
    bit              m_occ = 0;
    bit              m_hit = 0;
    longint unsigned m_addr = 0;
    bit              m_write = 0;

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_hit(longint unsigned a, bit wr, bit en, int md,
                                   longint unsigned pat, longint unsigned msk);
        longint unsigned pn, d;
        pn = (a & ((64'd1 << 56) - 1)) >> 12;
        d  = (pn ^ pat) & ~msk & ((64'd1 << 44) - 1);
        return en && wr && (md == 1) && (d == 0);
    endfunction

    // One clock: compare outputs, drive inputs, advance the model.
    task automatic cycle(bit v, longint unsigned a, bit wr, bit en, int md,
                         longint unsigned pat, longint unsigned msk, bit tr, bit wrdy);
        bit exp_rdy, acc, nh;
        @(negedge clk);
        chk({phase_tag, " trap_valid"}, trap_valid, m_occ && m_hit);
        chk({phase_tag, " walk_valid"}, walk_valid, m_occ && !m_hit);
        chk("R10 exclusive", trap_valid && walk_valid, 0);
        if (m_occ && m_hit) begin
            chk("R5 trap_addr", trap_addr, m_addr);
            chk("R5 page_mask", trap_page_mask, 64'hFFF);
            chk("R5 target", trap_target, 1);
            chk("R5 match", res_match, 1);
        end
        if (m_occ && !m_hit) begin
            chk("R6 walk_addr", walk_addr, m_addr);
            chk("R6 walk_write", walk_write, m_write);
            chk("R6 match", res_match, 0);
        end
        req_valid   = v;
        req_addr    = a[55:0];
        req_write   = wr;
        msi_enable  = en;
        ctx_mode    = 4'(md);
        ctx_pattern = pat[43:0];
        ctx_mask    = msk[43:0];
        trap_ready  = tr;
        walk_ready  = wrdy;
        #1;
        exp_rdy = !m_occ || (m_hit ? tr : wrdy);
        chk("R8 req_ready", req_ready, exp_rdy);
        acc = v && exp_rdy;
        nh  = ref_hit(a, wr, en, md, pat, msk);
        @(posedge clk);
        if (acc) begin
            m_occ = 1; m_hit = nh; m_addr = a & ((64'd1 << 56) - 1); m_write = wr;
        end else if (m_occ && (m_hit ? tr : wrdy)) begin
            m_occ = 0;
        end
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);
    endtask

    initial begin
        longint unsigned base, pg;
        rst_n = 0;
        req_valid = 0; req_addr = '0; req_write = 0; msi_enable = 0;
        ctx_mode = '0; ctx_pattern = '0; ctx_mask = '0;
        trap_ready = 1; walk_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 trap_valid", trap_valid, 0);
        chk("R9 walk_valid", walk_valid, 0);
        chk("R9 req_ready", req_ready, 1);
        @(posedge clk);
        rst_n = 1;

        base = 64'h00AB_CDEF_1234_5678;
        pg   = base >> 12;

        phase_tag = "R3 exact";
        cycle(1, base, 1, 1, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R1 disabled";
        cycle(1, base, 1, 0, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R4 read";
        cycle(1, base, 0, 1, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R2 mode0";
        cycle(1, base, 1, 1, 0, pg, 0, 1, 1);
        phase_tag = "R2 mode2";
        cycle(1, base, 1, 1, 2, pg, 0, 1, 1);
        phase_tag = "R2 mode15";
        cycle(1, base, 1, 1, 15, pg, 0, 1, 1);
        idle();
        phase_tag = "R3 unmasked diff";
        cycle(1, base, 1, 1, 1, pg ^ 64'h20, 0, 1, 1);
        phase_tag = "R3 masked diff";
        cycle(1, base, 1, 1, 1, pg ^ 64'h20, 64'h20, 1, 1);
        phase_tag = "R3 top bit";
        cycle(1, base, 1, 1, 1, pg ^ (64'd1 << 43), 0, 1, 1);
        phase_tag = "R3 bit0";
        cycle(1, base, 1, 1, 1, pg ^ 64'd1, 0, 1, 1);
        phase_tag = "R3 full mask";
        cycle(1, base, 1, 1, 1, 0, (64'd1 << 44) - 1, 1, 1);
        idle();
        phase_tag = "R11 offset";
        for (int i = 0; i < 6; i++)
            cycle(1, (base & ~64'hFFF) | (i * 64'h333), 1, 1, 1, pg, 0, 1, 1);
        cycle(1, base | 64'hFFF, 1, 1, 1, pg, 0, 1, 1);
        cycle(1, base & ~64'hFFF, 1, 1, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R7 back-to-back";
        for (int i = 0; i < 6; i++)
            cycle(1, base + i * 64'h1000, 1, 1, 1, pg, 64'h3, 1, 1);
        idle();
        phase_tag = "R8 trap stall";
        cycle(1, base, 1, 1, 1, pg, 0, 0, 1);
        for (int i = 0; i < 4; i++)
            cycle(1, base + 64'h5000, 1, 1, 1, pg, 0, 0, 1);
        cycle(1, base + 64'h5000, 1, 1, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R8 walk stall";
        cycle(1, base, 0, 1, 1, pg, 0, 1, 0);
        for (int i = 0; i < 4; i++)
            cycle(1, base + 64'h7000, 1, 1, 1, pg, 0, 1, 0);
        cycle(1, base, 1, 1, 1, pg, 0, 1, 1);
        idle();
        phase_tag = "R10 random";
        for (int i = 0; i < 600; i++) begin
            longint unsigned a, p, m;
            a = {$urandom, $urandom};
            p = (a >> 12) ^ (($urandom % 4 == 0) ? (64'd1 << ($urandom % 44)) : 0);
            m = ($urandom % 3 == 0) ? {$urandom, $urandom} : 0;
            cycle($urandom % 4 != 0, a, $urandom % 5 != 0, $urandom % 6 != 0,
                  ($urandom % 5 == 0) ? 2 : 1, p, m, $urandom % 3 != 0, $urandom % 3 != 0);
        end
        idle();
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule